// File: doc/BRIEF.md
# RAM-based content addressable memory

This block is a 32-entry content addressable memory whose entries each hold a 10-bit key. Instead of one comparator per entry, it keeps a 1024 x 32 presence array. A row is selected by key value, and a column is selected by entry index. Searching is one read of that array: the key is the row address, and the row that comes back is the match vector, with one bit per entry.

Storing and erasing go through a one-bit write view of the same array. The 15-bit write address names a single presence bit:
- the key sits in the upper ten bits;
- the entry index sits in the lower five bits.

Writing 1 stores the key in that entry, and writing 0 erases it. The block does not remember which key an entry held. To move an entry to a new key, the user clears the old key's bit and then sets the new one. Several entries may hold the same key, and a later stage picks among the hits.

After reset the block clears every row, one per cycle, and holds a busy flag for the whole pass.

Top module: `ram_cam`

## Requirements
- R1: While rst_ni is low, busy_o is 1, match_o is 0 and match_vld_o is 0. After rst_ni rises, busy_o stays 1 for exactly 1024 clock edges and then stays 0.
- R2: While busy_o is 1, searches and writes are ignored. match_vld_o stays 0, and a bit written during the pass is not present afterwards.
- R3: A search accepted at edge N (srch_en_i=1, busy_o=0) makes match_vld_o 1 after edge N+1 and loads match_o with the row for srch_key_i. match_vld_o is 0 after any edge with no accepted search.
- R4: A write with wr_bit_i=1 sets bit wr_addr_i[4:0] of the row wr_addr_i[14:5]. A later search of key wr_addr_i[14:5] then returns that bit set.
- R5: A write with wr_bit_i=0 clears only the addressed bit, and the other entries of that row keep their state.
- R6: Several entries may hold one key. A search returns all of their bits set at once.
- R7: When a write and a search address the same row in one cycle, the search returns the row contents from before the write.
- R8: match_o keeps its value in every cycle with no accepted search.
- R9: A write touches one row only. To replace a key, the old key's bit is cleared and then the new key's bit is set, after which each key's row reflects the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write one presence bit |
| wr_addr_i | input | 15 | {key[9:0], entry index[4:0]} |
| wr_bit_i | input | 1 | 1 stores the key in the entry, 0 erases it |
| srch_en_i | input | 1 | Start a search |
| srch_key_i | input | 10 | Key to search for |
| match_o | output | 32 | One bit per entry holding the searched key |
| match_vld_o | output | 1 | match_o updated by a search this cycle |
| busy_o | output | 1 | Reset clearing pass in progress |

## Verification
Two situations are hard to reach from the ports.

The first is a write and a search landing on the same row in the same cycle, because random keys rarely collide. The bench forces this collision directly. Its random phase also draws keys from a range of only sixteen values, so that collisions, multiple hits and replacements all recur often.

The second is the end of the clearing pass. The bench drives searches and writes on every cycle of the pass, counts the busy cycles exactly, and then confirms that nothing written during the pass survived.

// File: rtl/ramcam_pkg.sv
package ramcam_pkg;
  parameter int unsigned CAM_KEY_W = 10;
  parameter int unsigned CAM_IDX_W = 5;
endpackage

// File: rtl/cam_init_seq.sv
module cam_init_seq #(
  parameter int unsigned KEY_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             busy_o,
  output logic [KEY_W-1:0] row_o
);
  localparam logic [KEY_W-1:0] LAST_ROW = '1;

  logic [KEY_W-1:0] row_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      row_q <= row_q + 1'b1;
      if (row_q == LAST_ROW) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign row_o  = row_q;
endmodule

// File: rtl/cam_bit_ram.sv
// Row-wide read port, single-bit write port, whole-row clear port.
module cam_bit_ram #(
  parameter int unsigned KEY_W = 10,
  parameter int unsigned IDX_W = 5,
  localparam int unsigned ROWS = 1 << KEY_W,
  localparam int unsigned COLS = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_en_i,
  input  logic [KEY_W-1:0] clr_row_i,
  input  logic             we_i,
  input  logic [KEY_W-1:0] wr_row_i,
  input  logic [IDX_W-1:0] wr_col_i,
  input  logic             wr_bit_i,
  input  logic             re_i,
  input  logic [KEY_W-1:0] rd_row_i,
  output logic [COLS-1:0]  rd_data_o
);
  logic [COLS-1:0] mem [ROWS];
  logic [COLS-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (clr_en_i) mem[clr_row_i] <= '0;
    else if (we_i) mem[wr_row_i][wr_col_i] <= wr_bit_i;
  end

  // read-before-write: the nonblocking update is not visible to this read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else if (re_i) rd_q <= mem[rd_row_i];
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/ram_cam.sv
module ram_cam
  import ramcam_pkg::*;
#(
  parameter int unsigned KEY_W = CAM_KEY_W,
  parameter int unsigned IDX_W = CAM_IDX_W,
  localparam int unsigned ENTRIES = 1 << IDX_W,
  localparam int unsigned WA_W    = KEY_W + IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [WA_W-1:0]    wr_addr_i,
  input  logic               wr_bit_i,
  input  logic               srch_en_i,
  input  logic [KEY_W-1:0]   srch_key_i,
  output logic [ENTRIES-1:0] match_o,
  output logic               match_vld_o,
  output logic               busy_o
);
  logic             busy;
  logic [KEY_W-1:0] init_row;
  logic             srch_ok, wr_ok;
  logic             vld_q;

  cam_init_seq #(.KEY_W(KEY_W)) u_init (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_o (busy),
    .row_o  (init_row)
  );

  assign srch_ok = srch_en_i & ~busy;
  assign wr_ok   = wr_en_i & ~busy;

  cam_bit_ram #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_en_i  (busy),
    .clr_row_i (init_row),
    .we_i      (wr_ok),
    .wr_row_i  (wr_addr_i[IDX_W +: KEY_W]),
    .wr_col_i  (wr_addr_i[IDX_W-1:0]),
    .wr_bit_i  (wr_bit_i),
    .re_i      (srch_ok),
    .rd_row_i  (srch_key_i),
    .rd_data_o (match_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= srch_ok;
  end

  assign match_vld_o = vld_q;
  assign busy_o      = busy;
endmodule

// File: rtl/ram_cam_chk.sv
module ram_cam_chk #(
  parameter int unsigned KEY_W = 10,
  parameter int unsigned IDX_W = 5,
  localparam int unsigned ENTRIES = 1 << IDX_W,
  localparam int unsigned WA_W    = KEY_W + IDX_W,
  localparam int unsigned ROWS    = 1 << KEY_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [WA_W-1:0]    wr_addr_i,
  input logic               wr_bit_i,
  input logic               srch_en_i,
  input logic [KEY_W-1:0]   srch_key_i,
  input logic [ENTRIES-1:0] match_o,
  input logic               match_vld_o,
  input logic               busy_o
);
  logic [KEY_W:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
  end

  AST_BUSY_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> busy_cnt < (KEY_W+1)'(ROWS)); // R1
  AST_BUSY_STAYS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !busy_o); // R1
  AST_BUSY_IGNORES_SRCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !match_vld_o); // R2
  AST_SRCH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srch_en_i && !busy_o) |=> match_vld_o); // R3
  AST_NO_SRCH_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srch_en_i |=> !match_vld_o); // R3
  AST_MATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_vld_o |-> $stable(match_o)); // R8
endmodule

bind ram_cam ram_cam_chk #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/ram_cam_bench.sv
`timescale 1ns/1ps
module ram_cam_bench;
  localparam int KEY_W = 10;
  localparam int IDX_W = 5;
  localparam int ROWS  = 1 << KEY_W;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [14:0] wr_addr_i = '0;
  logic        wr_bit_i = 1'b0;
  logic        srch_en_i = 1'b0;
  logic [9:0]  srch_key_i = '0;
  logic [31:0] match_o;
  logic        match_vld_o;
  logic        busy_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] model [ROWS];

  always #2.5 clk_i = ~clk_i;

  ram_cam u_ram_cam (.*);

  function automatic logic [14:0] waddr(input logic [9:0] key, input logic [4:0] idx);
    return {key, idx};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  // one cycle: optional write and optional search, then check the result
  task automatic op(input string req, input bit we, input logic [9:0] wkey,
                    input logic [4:0] widx, input bit wbit, input bit se,
                    input logic [9:0] skey);
    logic [31:0] exp;
    exp = model[skey];
    wr_en_i = we; wr_addr_i = waddr(wkey, widx); wr_bit_i = wbit;
    srch_en_i = se; srch_key_i = skey;
    if (we) model[wkey][widx] = wbit;
    cyc();
    wr_en_i = 1'b0; srch_en_i = 1'b0;
    if (se) begin
      chk({req, " vld"}, {31'd0, match_vld_o}, 32'd1);
      chk(req, match_o, exp);
    end
  endtask

  task automatic wr(input logic [9:0] k, input logic [4:0] i, input bit b);
    op("wr", 1'b1, k, i, b, 1'b0, '0);
  endtask

  task automatic sr(input string req, input logic [9:0] k);
    op(req, 1'b0, '0, '0, 1'b0, 1'b1, k);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int busy_n;
    logic [31:0] held;
    void'($urandom(32'd4242));
    for (int r = 0; r < ROWS; r++) model[r] = '0;
    repeat (3) cyc();
    chk("R1 busy in reset", {31'd0, busy_o}, 32'd1);
    chk("R1 match in reset", match_o, 32'd0);
    chk("R1 vld in reset", {31'd0, match_vld_o}, 32'd0);

    // release reset; hammer searches and writes during the pass
    rst_ni = 1'b1;
    wr_en_i = 1'b1; wr_addr_i = waddr(10'd5, 5'd3); wr_bit_i = 1'b1;
    srch_en_i = 1'b1; srch_key_i = 10'd5;
    busy_n = 0;
    begin
      bit vld_seen = 1'b0;
      while (busy_o && busy_n < 2000) begin
        busy_n++;
        cyc();
        if (match_vld_o) vld_seen = 1'b1;
      end
      wr_en_i = 1'b0; srch_en_i = 1'b0;
      chk("R2 no vld while busy", {31'd0, vld_seen}, 32'd0);
    end
    chk("R1 busy length", busy_n, 1024);
    cyc();
    chk("R1 busy stays low", {31'd0, busy_o}, 32'd0);
    sr("R2 write during busy dropped", 10'd5);

    // directed
    wr(10'h3FF, 5'd31, 1'b1);
    sr("R4 top key top index", 10'h3FF);
    wr(10'h000, 5'd0, 1'b1);
    sr("R4 key 0 index 0", 10'h000);
    wr(10'h155, 5'd2, 1'b1); wr(10'h155, 5'd7, 1'b1); wr(10'h155, 5'd20, 1'b1);
    sr("R6 three hits", 10'h155);
    chk("R6 three hits value", match_o, 32'h0010_0084);
    wr(10'h155, 5'd7, 1'b0);
    sr("R5 clear one bit", 10'h155);
    chk("R5 clear value", match_o, 32'h0010_0004);
    // replace entry 4: key 0x0AA -> 0x0AB
    wr(10'h0AA, 5'd4, 1'b1);
    wr(10'h0AA, 5'd4, 1'b0);
    wr(10'h0AB, 5'd4, 1'b1);
    sr("R9 old key row", 10'h0AA);
    sr("R9 new key row", 10'h0AB);
    sr("R9 neighbour row", 10'h0AC);
    // same-row write and search in one cycle
    op("R7 same cycle old data", 1'b1, 10'h155, 5'd9, 1'b1, 1'b1, 10'h155);
    chk("R7 old value", match_o, 32'h0010_0004);
    sr("R7 new data next", 10'h155);
    // hold
    held = match_o;
    wr(10'h155, 5'd0, 1'b1);
    cyc(); cyc();
    chk("R8 hold value", match_o, held);
    chk("R3 vld low idle", {31'd0, match_vld_o}, 32'd0);

    // random
    for (int n = 0; n < 400; n++) begin
      bit we, se;
      logic [9:0] wk, sk;
      we = ($urandom % 3) != 0;
      se = ($urandom % 2) != 0;
      wk = 10'($urandom % 16);
      sk = (($urandom % 4) == 0) ? wk : 10'($urandom % 16);
      op("R3 random", we, wk, 5'($urandom), 1'($urandom), se, sk);
    end
    for (int k = 0; k < 16; k++) sr("R4 sweep", 10'(k));

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule